// File: doc/BRIEF.md
# DRAM Address Multiplexer with Refresh Counter

This block forms the multiplexed address bus of a dynamic RAM array. Each cycle it drives one of three values onto a 10-bit output: a held row address, a held column address, or the value of an internal refresh counter. A two-bit bank select is held in the same way and comes out beside the address. Row, column and bank inputs each pass through a latch that is transparent while the address strobe is high. The latch keeps its value while the strobe is low.

A small state machine chooses the source. The mode and select inputs are sampled on the system clock, and the result takes effect after that edge. There are three states: `ST_ROW` drives the row view, `ST_COL` drives the column view and `ST_RFSH` drives the refresh count. From any state the next state is `ST_RFSH` when the refresh mode input is high. Otherwise it is `ST_COL` when the column select is high, and `ST_ROW` when it is low. Leaving `ST_RFSH` (refresh mode sampled low while in `ST_RFSH`) completes a refresh and advances the counter. A low level on the active-low clear input, sampled on a clock edge, zeroes the counter. The clear wins over an advance in the same cycle.

Top module: `dram_addr_mux`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the state is `ST_ROW`, the refresh count is 0 and the held row, column and bank values are 0.
- R2: While `addr_strobe` is high, `mux_addr` follows the selected row or column input in the same cycle, and `bank_out` follows `bank_sel` in the same cycle.
- R3: While `addr_strobe` is low, the row, column and bank views hold the input values sampled at the last clock edge where `addr_strobe` was high. Input changes have no effect on `mux_addr` or `bank_out`.
- R4: When `refresh_mode` is low, `col_select` sampled at a clock edge selects the source from that edge onward: 0 selects the row view (`ST_ROW`) and 1 selects the column view (`ST_COL`).
- R5: When `refresh_mode` is sampled high, the state is `ST_RFSH` from that edge onward, whatever `col_select` is. The output then carries the refresh count for every cycle of the refresh.
- R6: The counter advances by one at the edge that leaves `ST_RFSH`, and not while a refresh is running. The advanced value shows on the next refresh.
- R7: The refresh counter is 9 bits wide and wraps from 511 to 0.
- R8: When `rfsh_clr_n` is sampled low at an edge, the counter becomes 0, even if a refresh ends at that same edge.
- R9: During `ST_RFSH`, `mux_addr[9]` is 0 and `mux_addr[8:0]` equals the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_addr | input | 10 | Row address input |
| col_addr | input | 10 | Column address input |
| bank_sel | input | 2 | Bank select input |
| addr_strobe | input | 1 | High: latches transparent; low: hold |
| col_select | input | 1 | 0 row, 1 column (access mode) |
| refresh_mode | input | 1 | High requests a refresh cycle |
| rfsh_clr_n | input | 1 | Low clears the refresh counter |
| mux_addr | output | 10 | Multiplexed DRAM address |
| bank_out | output | 2 | Held bank select |

## Verification
The bench drives the strobe high while the addresses change, then low while they change. This separates true fall-through from a registered copy that lags one cycle, and from a latch that never holds. It switches `col_select` with refresh mode both off and on, which shows whether refresh really takes priority over the select. It runs refreshes of one and of several cycles, which shows whether the count advances at the end of a refresh or at its start. A run of more than 512 refreshes exercises the wrap, and a clear that arrives on the same edge as a refresh end shows which of the two wins.

// File: rtl/dram_addr_mux_pkg.sv
package dram_addr_mux_pkg;
    typedef enum logic [1:0] {
        ST_ROW  = 2'd0,
        ST_COL  = 2'd1,
        ST_RFSH = 2'd2
    } amux_state_e;
endpackage

// File: rtl/dam_latch.sv
module dam_latch #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         le_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    held_q <= '0;
        else if (le_i) held_q <= d_i;
    end

    // fall-through while enabled, held value otherwise
    assign q_o = le_i ? d_i : held_q;

    // R3
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!le_i && !$past(le_i)) |-> $stable(q_o));

    // R3
    latch_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(le_i) && !le_i) |-> (q_o == $past(d_i)));
endmodule

// File: rtl/dam_rfsh_ctr.sv
module dam_rfsh_ctr #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             clr_n_i,
    output logic [CNT_W-1:0] cnt_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_o <= '0;
        else if (!clr_n_i) cnt_o <= '0;
        else if (inc_i)    cnt_o <= cnt_o + 1'b1;
    end

    // R8
    ctr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n_i |=> (cnt_o == '0));

    // R6
    ctr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n_i && !inc_i) |=> $stable(cnt_o));

    // R7
    ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n_i && inc_i) |=> (cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
    import dram_addr_mux_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int CNT_W  = 9,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] row_addr,
    input  logic [ADDR_W-1:0] col_addr,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic              addr_strobe,
    input  logic              col_select,
    input  logic              refresh_mode,
    input  logic              rfsh_clr_n,
    output logic [ADDR_W-1:0] mux_addr,
    output logic [BANK_W-1:0] bank_out
);
    localparam int PAD_W = ADDR_W - CNT_W;

    amux_state_e       state_q, state_d;
    logic [ADDR_W-1:0] row_view, col_view, rfsh_view;
    logic [CNT_W-1:0]  rfsh_cnt;
    logic              rfsh_done;

    dam_latch #(.W(ADDR_W)) u_row_lat (
        .clk(clk), .rst_n(rst_n), .le_i(addr_strobe), .d_i(row_addr), .q_o(row_view));
    dam_latch #(.W(ADDR_W)) u_col_lat (
        .clk(clk), .rst_n(rst_n), .le_i(addr_strobe), .d_i(col_addr), .q_o(col_view));
    dam_latch #(.W(BANK_W)) u_bank_lat (
        .clk(clk), .rst_n(rst_n), .le_i(addr_strobe), .d_i(bank_sel), .q_o(bank_out));

    assign rfsh_done = (state_q == ST_RFSH) && !refresh_mode;

    dam_rfsh_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .inc_i(rfsh_done), .clr_n_i(rfsh_clr_n), .cnt_o(rfsh_cnt));

    generate
        if (PAD_W > 0) begin : g_pad
            assign rfsh_view = {{PAD_W{1'b0}}, rfsh_cnt};
        end else begin : g_nopad
            assign rfsh_view = rfsh_cnt[ADDR_W-1:0];
        end
    endgenerate

    // next-state selection
    always_comb begin
        if (refresh_mode)    state_d = ST_RFSH;
        else if (col_select) state_d = ST_COL;
        else                 state_d = ST_ROW;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ROW;
        else        state_q <= state_d;
    end

    // output source per state
    always_comb begin
        unique case (state_q)
            ST_ROW:  mux_addr = row_view;
            ST_COL:  mux_addr = col_view;
            ST_RFSH: mux_addr = rfsh_view;
            default: mux_addr = row_view;
        endcase
    end

    // R5
    rfsh_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_mode |=> (state_q == ST_RFSH));

    // R4
    col_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!refresh_mode && col_select) |=> (mux_addr == col_view));

    // R9
    rfsh_topbit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RFSH) |-> (mux_addr[ADDR_W-1] == 1'b0));
endmodule

// File: tb/dram_addr_mux_tb_top.sv
module dram_addr_mux_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [9:0] row_addr, col_addr;
    logic [1:0] bank_sel;
    logic       addr_strobe, col_select, refresh_mode, rfsh_clr_n;
    logic [9:0] mux_addr;
    logic [1:0] bank_out;

    int total = 0;
    int bad   = 0;

    // behavioural reference state: 0 row, 1 col, 2 refresh
    int m_state = 0;
    int m_cnt   = 0;
    int m_row   = 0;
    int m_col   = 0;
    int m_bank  = 0;

    always #5 clk = ~clk;

    dram_addr_mux dut_i (
        .clk(clk), .rst_n(rst_n), .row_addr(row_addr), .col_addr(col_addr),
        .bank_sel(bank_sel), .addr_strobe(addr_strobe), .col_select(col_select),
        .refresh_mode(refresh_mode), .rfsh_clr_n(rfsh_clr_n),
        .mux_addr(mux_addr), .bank_out(bank_out));

    task automatic check_now(input string tag);
        int rv, cv, bv, ea;
        rv = addr_strobe ? int'(row_addr) : m_row;
        cv = addr_strobe ? int'(col_addr) : m_col;
        bv = addr_strobe ? int'(bank_sel) : m_bank;
        if (m_state == 2)      ea = m_cnt;
        else if (m_state == 1) ea = cv;
        else                   ea = rv;
        total++;
        if (int'(mux_addr) != ea || int'(bank_out) != bv) begin
            bad++;
            $display("FAIL %s addr=%0d bank=%0d expected addr=%0d bank=%0d",
                     tag, mux_addr, bank_out, ea, bv);
        end
    endtask

    task automatic model_edge();
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_row = 0; m_col = 0; m_bank = 0;
        end else begin
            if (addr_strobe) begin
                m_row = int'(row_addr); m_col = int'(col_addr); m_bank = int'(bank_sel);
            end
            if (!rfsh_clr_n)                      m_cnt = 0;
            else if (m_state == 2 && !refresh_mode) m_cnt = (m_cnt + 1) % 512;
            if (refresh_mode)    m_state = 2;
            else if (col_select) m_state = 1;
            else                 m_state = 0;
        end
    endtask

    // drive inputs, check the settled output, then clock
    task automatic step(input string tag, input logic [9:0] r, input logic [9:0] c,
                        input logic [1:0] b, input logic stb, input logic cs,
                        input logic rm, input logic clr_n);
        row_addr = r; col_addr = c; bank_sel = b;
        addr_strobe = stb; col_select = cs; refresh_mode = rm; rfsh_clr_n = clr_n;
        #1;
        check_now(tag);
        @(posedge clk);
        model_edge();
        #2;
    endtask

    initial begin
        #200000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        @(negedge clk);
        step("R1", 10'd5, 10'd6, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1);
        step("R1", 10'd7, 10'd8, 2'd2, 1'b0, 1'b1, 1'b1, 1'b1);
        rst_n = 1'b1;
        step("R1", 10'd9, 10'd3, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1);
        // R2 fall-through with a changing row
        step("R2", 10'h155, 10'h0AA, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1);
        step("R2", 10'h3FF, 10'h001, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1);
        step("R2", 10'h2A5, 10'h15A, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1);
        step("R2", 10'h111, 10'h222, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1);
        // R3 hold with inputs moving
        step("R3", 10'h0F0, 10'h00F, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1);
        step("R3", 10'h333, 10'h044, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1);
        step("R3", 10'h3C3, 10'h2BB, 2'd2, 1'b0, 1'b1, 1'b0, 1'b1);
        // R4 alternate selection
        for (int i = 0; i < 6; i++)
            step("R4", 10'(i * 37), 10'(1000 - i), 2'(i), 1'b1, 1'(i % 2), 1'b0, 1'b1);
        // R5 and R9: long refresh with column select high
        for (int i = 0; i < 4; i++)
            step("R5", 10'h3FF, 10'h3FE, 2'd3, 1'b1, 1'b1, 1'b1, 1'b1);
        // R6: refresh end advances
        step("R6", 10'h12, 10'h34, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1);
        step("R6", 10'h12, 10'h34, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1);
        step("R9", 10'h12, 10'h34, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1);
        step("R6", 10'h12, 10'h34, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1);
        step("R6", 10'h12, 10'h34, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1);
        // R8: clear on the same edge the refresh ends
        step("R8", 10'h12, 10'h34, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
        step("R8", 10'h12, 10'h34, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1);
        step("R8", 10'h12, 10'h34, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1);
        // R8: clear during an access cycle
        step("R8", 10'h12, 10'h34, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
        step("R8", 10'h12, 10'h34, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1);
        // R7: many short refreshes through the wrap
        for (int i = 0; i < 520; i++) begin
            step("R7", 10'(i), 10'(i + 3), 2'(i), 1'b1, 1'(i % 3 == 0), 1'b1, 1'b1);
            step("R7", 10'(i), 10'(i + 3), 2'(i), 1'b1, 1'(i % 3 == 0), 1'b0, 1'b1);
        end
        step("R9", 10'h3FF, 10'h3FF, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1);
        step("R9", 10'h3FF, 10'h3FF, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule